// File: doc/BRIEF.md
# Quadrature Position Counter with Index and Home Reload

This block turns two quadrature channels into a signed position count and keeps a signed 16-bit revolution count next to it. A second mode counts rising edges on channel A alone, and a direction pin chooses up or down. Every input pin passes through a two-flop synchroniser. It then passes through a glitch filter whose length is programmable. Edge detection follows the filter.

Software programs a lower and an upper position bound. When the count steps past one bound it wraps to the other bound and moves the revolution count by one. An index pin reloads the position to the lower bound and also moves the revolution count. A home pin reloads the position to a programmable start value and leaves the revolution count alone. A comparator drives a level output for as long as the position equals a match value. The same comparator raises a single event, which fires again only after software re-arms it. Six sticky flags are ORed into one interrupt line.

Register map (4-bit address; reads are combinational, writes happen on the clock edge):

| Addr | Register | Content |
|------|----------|---------|
| 0 | ctrl | bit 0 pulse mode, bits 2:1 resolution, bit 3 index enable, bit 4 home enable, bit 5 match enable (writing a 1 here also arms the event) |
| 1 | filt | filter length |
| 2 | lo | lower bound |
| 3 | hi | upper bound |
| 4 | start | value loaded by home |
| 5 | cmp | match value |
| 6 | pos | position |
| 7 | rev | revolution count |
| 8 | flags | sticky event flags, write 1 to clear |

Positions and revolution counts read back sign-extended to 32 bits.

Top module: `qpos_counter`

## Requirements
- R1: In quadrature mode (ctrl bit 0 = 0), one full forward cycle is the input sequence {A,B} = 00, 10, 11, 01, and it counts up. The reverse order counts down. The resolution field (ctrl bits 2:1) sets how many steps count: 2 = every step, 1 = only steps where A changes, 0 = only the 00<->10 step, so one count per cycle.
- R2: A sample in which A and B both change is not counted and sets flag bit 5.
- R3: Counting up while the position equals the upper bound loads the lower bound, adds one to the revolution count and sets flag bit 3.
- R4: Counting down while the position equals the lower bound loads the upper bound, subtracts one from the revolution count and sets flag bit 4.
- R5: When both bounds are 0, the window is the full signed 16-bit range: stepping up from 32767 gives -32768 with revolution +1, and stepping back restores 32767 with revolution -1.
- R6: With ctrl bit 3 set, a rising edge on the index pin loads the lower bound, sets flag bit 1, and adds one to the revolution count if the last counting direction was up or subtracts one if it was down. With bit 3 clear, the index pin has no effect.
- R7: With ctrl bit 4 set, a rising edge on the home pin loads the start value, leaves the revolution count unchanged and sets flag bit 0.
- R8: A write to rev leaves the position unchanged. The read data during the write cycle shows the previous revolution count.
- R9: match_o is high while ctrl bit 5 is set and the position equals cmp.
- R10: The match event sets flag bit 2 once and then stays disarmed until ctrl is written again with bit 5 set.
- R11: Flags stay set until a 1 is written to their bit in flags. irq_o is high while any flag is set.
- R12: In pulse mode (ctrl bit 0 = 1), each rising edge of A counts up when dir_i is low and down when dir_i is high.
- R13: A synchronised level is accepted once it has held for filt+1 clock cycles. Shorter pulses are dropped. filt = 0 passes a one-cycle pulse.
- R14: After reset, position, revolution count, flags, irq_o and match_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| a_i | input | 1 | quadrature channel A, or the pulse input in pulse mode |
| b_i | input | 1 | quadrature channel B |
| dir_i | input | 1 | pulse-mode direction, low = up |
| idx_i | input | 1 | index pin |
| home_i | input | 1 | home reload pin |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 4 | register address |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data |
| match_o | output | 1 | position equals the match value |
| irq_o | output | 1 | OR of all flags |

## Verification
Most faults in the counting path show up at the pos and rev registers within about five clock cycles of an input edge. A wrong decode step or a wrong wrap target appears directly as a wrong position value. A corrupted last-direction state stays hidden until the next index pulse, which then moves the revolution count the wrong way. A disarm that fails, or a flag that fails to stick, shows at irq_o as soon as software clears the flags while the position still equals the match value.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  localparam int CYC_W  = 16;
  localparam int FLAG_N = 6;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_FILT  = 4'd1;
  localparam logic [3:0] A_LO    = 4'd2;
  localparam logic [3:0] A_HI    = 4'd3;
  localparam logic [3:0] A_START = 4'd4;
  localparam logic [3:0] A_CMP   = 4'd5;
  localparam logic [3:0] A_POS   = 4'd6;
  localparam logic [3:0] A_REV   = 4'd7;
  localparam logic [3:0] A_FLAGS = 4'd8;

  localparam int FL_HOME = 0;
  localparam int FL_IDX  = 1;
  localparam int FL_CMP  = 2;
  localparam int FL_OVF  = 3;
  localparam int FL_UNF  = 4;
  localparam int FL_ERR  = 5;

  localparam logic [1:0] RES_X1 = 2'd0;
  localparam logic [1:0] RES_X2 = 2'd1;

  typedef struct packed {
    logic       match_en;
    logic       home_en;
    logic       idx_en;
    logic [1:0] res;
    logic       pulse_mode;
  } ctrl_t;
endpackage

// File: rtl/qpos_filter.sv
module qpos_filter #(
  parameter int FILT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [FILT_W-1:0] filt_i,
  output logic              out_o
);
  logic [1:0]        sync_q;
  logic [FILT_W-1:0] cnt_q;
  logic              out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q >= filt_i) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o = out_q;

  // R13
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != sync_q[1]) && (cnt_q < filt_i) |=> $stable(out_q));
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_mode_i,
  input  logic [1:0] res_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       dir_i,
  input  logic       idx_i,
  input  logic       home_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       err_o,
  output logic       dir_dn_o,
  output logic       idx_rise_o,
  output logic       home_rise_o
);
  logic [1:0] ab_q;
  logic       idx_q, home_q, last_dn_q;
  logic [1:0] ab, ph_now, ph_old;
  logic       fwd, bwd, a_chg, both, a_rise;
  logic       q_up, q_dn;

  function automatic logic [1:0] phase_of(logic [1:0] v);
    case (v)
      2'b00:   return 2'd0;
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  assign ab     = {a_i, b_i};
  assign ph_now = phase_of(ab);
  assign ph_old = phase_of(ab_q);
  assign fwd    = ph_now == 2'(ph_old + 2'd1);
  assign bwd    = ph_old == 2'(ph_now + 2'd1);
  assign a_chg  = ab[1] ^ ab_q[1];
  assign both   = &(ab ^ ab_q);
  assign a_rise = ab[1] & ~ab_q[1];

  always_comb begin
    case (res_i)
      RES_X1: begin q_up = fwd && ph_old == 2'd0; q_dn = bwd && ph_now == 2'd0; end
      RES_X2: begin q_up = fwd && a_chg;          q_dn = bwd && a_chg;          end
      default: begin q_up = fwd;                  q_dn = bwd;                   end
    endcase
  end

  assign up_o        = pulse_mode_i ? a_rise & ~dir_i : q_up;
  assign dn_o        = pulse_mode_i ? a_rise &  dir_i : q_dn;
  assign err_o       = ~pulse_mode_i & both;
  assign dir_dn_o    = pulse_mode_i ? dir_i : last_dn_q;
  assign idx_rise_o  = idx_i & ~idx_q;
  assign home_rise_o = home_i & ~home_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_q      <= '0;
      idx_q     <= 1'b0;
      home_q    <= 1'b0;
      last_dn_q <= 1'b0;
    end else begin
      ab_q   <= ab;
      idx_q  <= idx_i;
      home_q <= home_i;
      if (!pulse_mode_i && q_up)      last_dn_q <= 1'b0;
      else if (!pulse_mode_i && q_dn) last_dn_q <= 1'b1;
    end
  end

  // R1
  step_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_o, dn_o}));
endmodule

// File: rtl/qpos_core.sv
module qpos_core
  import qpos_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  ctrl_t                   ctrl_i,
  input  logic signed [POS_W-1:0] lo_i,
  input  logic signed [POS_W-1:0] hi_i,
  input  logic signed [POS_W-1:0] start_i,
  input  logic signed [POS_W-1:0] cmp_i,
  input  logic                    up_i,
  input  logic                    dn_i,
  input  logic                    err_i,
  input  logic                    dir_dn_i,
  input  logic                    idx_rise_i,
  input  logic                    home_rise_i,
  input  logic                    pos_we_i,
  input  logic signed [POS_W-1:0] pos_wdata_i,
  input  logic                    rev_we_i,
  input  logic signed [CYC_W-1:0] rev_wdata_i,
  input  logic                    arm_set_i,
  input  logic [FLAG_N-1:0]       flag_clr_i,
  output logic signed [POS_W-1:0] pos_o,
  output logic signed [CYC_W-1:0] rev_o,
  output logic [FLAG_N-1:0]       flags_o,
  output logic                    match_o
);
  localparam logic signed [POS_W-1:0] NAT_MIN = {1'b1, {(POS_W-1){1'b0}}};
  localparam logic signed [POS_W-1:0] NAT_MAX = {1'b0, {(POS_W-1){1'b1}}};

  logic signed [POS_W-1:0] pos_q, pos_d, lo, hi;
  logic signed [CYC_W-1:0] rev_q, rev_d;
  logic [FLAG_N-1:0]       flags_q, flag_set;
  logic                    armed_q, full, home_evt, idx_evt, ovf, unf, match_evt;

  assign full     = (lo_i == '0) && (hi_i == '0);
  assign lo       = full ? NAT_MIN : lo_i;
  assign hi       = full ? NAT_MAX : hi_i;
  assign home_evt = home_rise_i & ctrl_i.home_en;
  assign idx_evt  = idx_rise_i & ctrl_i.idx_en;

  always_comb begin
    pos_d = pos_q;
    rev_d = rev_q;
    ovf   = 1'b0;
    unf   = 1'b0;
    if (pos_we_i) begin
      pos_d = pos_wdata_i;
    end else if (home_evt) begin
      pos_d = start_i;
    end else if (idx_evt) begin
      pos_d = lo;
      rev_d = dir_dn_i ? rev_q - 16'sd1 : rev_q + 16'sd1;
    end else if (up_i) begin
      if (pos_q == hi) begin
        pos_d = lo;
        rev_d = rev_q + 16'sd1;
        ovf   = 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end else if (dn_i) begin
      if (pos_q == lo) begin
        pos_d = hi;
        rev_d = rev_q - 16'sd1;
        unf   = 1'b1;
      end else begin
        pos_d = pos_q - 1'b1;
      end
    end
    if (rev_we_i) rev_d = rev_wdata_i;
  end

  assign match_o   = ctrl_i.match_en && (pos_q == cmp_i);
  assign match_evt = match_o & armed_q;
  assign flag_set  = {err_i, unf, ovf, match_evt, idx_evt, home_evt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      rev_q   <= '0;
      flags_q <= '0;
      armed_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      rev_q   <= rev_d;
      flags_q <= (flags_q & ~flag_clr_i) | flag_set;
      if (arm_set_i)      armed_q <= 1'b1;
      else if (match_evt) armed_q <= 1'b0;
    end
  end

  assign pos_o   = pos_q;
  assign rev_o   = rev_q;
  assign flags_o = flags_q;

  // R3
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_i && pos_q == hi && !pos_we_i && !home_evt && !idx_evt
    |=> pos_q == $past(lo) && flags_q[FL_OVF]);
  // R7
  home_rev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    home_evt && !rev_we_i |=> $stable(rev_q));
  // R10
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_evt && !arm_set_i |=> !armed_q);
  // R11
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[FL_ERR] && !flag_clr_i[FL_ERR] |=> flags_q[FL_ERR]);
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int FILT_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        a_i,
  input  logic        b_i,
  input  logic        dir_i,
  input  logic        idx_i,
  input  logic        home_i,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        match_o,
  output logic        irq_o
);
  localparam int IN_N = 5;

  ctrl_t                   ctrl_q;
  logic [FILT_W-1:0]       filt_q;
  logic signed [POS_W-1:0] lo_q, hi_q, start_q, cmp_q, pos;
  logic signed [CYC_W-1:0] rev;
  logic [FLAG_N-1:0]       flags, flag_clr;
  logic [IN_N-1:0]         raw, filt;
  logic                    up, dn, err, dir_dn, idx_rise, home_rise, arm_set;

  assign raw = {home_i, idx_i, dir_i, b_i, a_i};

  for (genvar g = 0; g < IN_N; g++) begin : g_filt
    qpos_filter #(.FILT_W(FILT_W)) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .filt_i(filt_q),
      .out_o (filt[g])
    );
  end

  qpos_decode i_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_mode_i(ctrl_q.pulse_mode),
    .res_i       (ctrl_q.res),
    .a_i         (filt[0]),
    .b_i         (filt[1]),
    .dir_i       (filt[2]),
    .idx_i       (filt[3]),
    .home_i      (filt[4]),
    .up_o        (up),
    .dn_o        (dn),
    .err_o       (err),
    .dir_dn_o    (dir_dn),
    .idx_rise_o  (idx_rise),
    .home_rise_o (home_rise)
  );

  assign arm_set  = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[5];
  assign flag_clr = (reg_we_i && reg_addr_i == A_FLAGS) ? reg_wdata_i[FLAG_N-1:0] : '0;

  qpos_core #(.POS_W(POS_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl_q),
    .lo_i       (lo_q),
    .hi_i       (hi_q),
    .start_i    (start_q),
    .cmp_i      (cmp_q),
    .up_i       (up),
    .dn_i       (dn),
    .err_i      (err),
    .dir_dn_i   (dir_dn),
    .idx_rise_i (idx_rise),
    .home_rise_i(home_rise),
    .pos_we_i   (reg_we_i && reg_addr_i == A_POS),
    .pos_wdata_i(reg_wdata_i[POS_W-1:0]),
    .rev_we_i   (reg_we_i && reg_addr_i == A_REV),
    .rev_wdata_i(reg_wdata_i[CYC_W-1:0]),
    .arm_set_i  (arm_set),
    .flag_clr_i (flag_clr),
    .pos_o      (pos),
    .rev_o      (rev),
    .flags_o    (flags),
    .match_o    (match_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      filt_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      start_q <= '0;
      cmp_q   <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata_i[5:0]);
        A_FILT:  filt_q  <= reg_wdata_i[FILT_W-1:0];
        A_LO:    lo_q    <= reg_wdata_i[POS_W-1:0];
        A_HI:    hi_q    <= reg_wdata_i[POS_W-1:0];
        A_START: start_q <= reg_wdata_i[POS_W-1:0];
        A_CMP:   cmp_q   <= reg_wdata_i[POS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = 32'(ctrl_q);
      A_FILT:  reg_rdata_o = 32'(filt_q);
      A_LO:    reg_rdata_o = 32'(lo_q);
      A_HI:    reg_rdata_o = 32'(hi_q);
      A_START: reg_rdata_o = 32'(start_q);
      A_CMP:   reg_rdata_o = 32'(cmp_q);
      A_POS:   reg_rdata_o = 32'(pos);
      A_REV:   reg_rdata_o = 32'(rev);
      A_FLAGS: reg_rdata_o = 32'(flags);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |flags;
endmodule

// File: tb/test_qpos_counter.sv
module test_qpos_counter;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 7;
  localparam int V_RES[VEC_N]   = '{2, 2, 1, 1, 0, 0, 0};
  localparam int V_STEPS[VEC_N] = '{7, -5, 7, -6, 8, -8, 3};
  localparam int V_EXP[VEC_N]   = '{7, -5, 4, -3, 2, -2, 1};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        a = 1'b0, b = 1'b0, dir = 1'b0, idx = 1'b0, home = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        match, irq;
  int          nchk = 0, nerr = 0, phase = 0, tmp;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpos_counter i_qpos_counter (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .dir_i(dir), .idx_i(idx),
    .home_i(home), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .match_o(match), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] ad, int d, output int prev);
    @(negedge clk);
    addr = ad; wdata = d; we = 1'b1;
    #1 prev = $signed(rdata);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic w(logic [3:0] ad, int d);
    int unused_v;
    wr(ad, d, unused_v);
  endtask

  task automatic rd(logic [3:0] ad, output int v);
    addr = ad;
    #1 v = $signed(rdata);
  endtask

  task automatic drive_phase();
    a = (phase == 1) || (phase == 2);
    b = (phase == 2) || (phase == 3);
    wait_n(5);
  endtask

  task automatic qstep(bit fwd);
    phase = (phase + (fwd ? 1 : 3)) % 4;
    drive_phase();
  endtask

  task automatic pin_pulse(ref logic p, input int len);
    p = 1'b1; wait_n(len);
    p = 1'b0; wait_n(8);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R14 reset state
    rd(4'd6, tmp); chk("R14 pos", tmp, 0);
    rd(4'd7, tmp); chk("R14 rev", tmp, 0);
    rd(4'd8, tmp); chk("R14 flags", tmp, 0);
    chk("R14 irq", irq, 0);
    chk("R14 match", match, 0);

    // R1 vector table
    for (int i = 0; i < VEC_N; i++) begin
      while (phase != 0) qstep(1'b1);
      w(4'd0, V_RES[i] << 1);
      w(4'd6, 0);
      for (int s = 0; s < (V_STEPS[i] < 0 ? -V_STEPS[i] : V_STEPS[i]); s++)
        qstep(V_STEPS[i] > 0);
      wait_n(3);
      rd(4'd6, tmp); chk($sformatf("R1 vec%0d pos", i), tmp, V_EXP[i]);
    end

    // R2 both channels change together
    w(4'd0, 4); w(4'd6, 0); w(4'd8, 63);
    a = ~a; b = ~b; phase = (phase + 2) % 4; wait_n(8);
    rd(4'd6, tmp); chk("R2 pos unchanged", tmp, 0);
    rd(4'd8, tmp); chk("R2 error flag", tmp, 32);
    chk("R11 irq set", irq, 1);
    w(4'd8, 63); wait_n(1);
    rd(4'd8, tmp); chk("R11 flags cleared", tmp, 0);
    chk("R11 irq cleared", irq, 0);

    // R3 / R4 window wrap
    w(4'd2, 2); w(4'd3, 5); w(4'd6, 5);
    qstep(1'b1); wait_n(2);
    rd(4'd6, tmp); chk("R3 pos", tmp, 2);
    rd(4'd7, tmp); chk("R3 rev", tmp, 1);
    rd(4'd8, tmp); chk("R3 flag", tmp, 8);
    qstep(1'b0); wait_n(2);
    rd(4'd6, tmp); chk("R4 pos", tmp, 5);
    rd(4'd7, tmp); chk("R4 rev", tmp, 0);
    rd(4'd8, tmp); chk("R4 flags", tmp, 24);
    w(4'd8, 63);

    // R5 native range
    w(4'd2, 0); w(4'd3, 0); w(4'd6, 32767);
    qstep(1'b1); wait_n(2);
    rd(4'd6, tmp); chk("R5 pos up", tmp, -32768);
    rd(4'd7, tmp); chk("R5 rev up", tmp, 1);
    qstep(1'b0); wait_n(2);
    rd(4'd6, tmp); chk("R5 pos down", tmp, 32767);
    rd(4'd7, tmp); chk("R5 rev down", tmp, 0);

    // R8 rev write returns previous
    wr(4'd7, 100, tmp); chk("R8 prev0", tmp, 0);
    wr(4'd7, 7, tmp); chk("R8 prev100", tmp, 100);
    rd(4'd7, tmp); chk("R8 rev", tmp, 7);
    rd(4'd6, tmp); chk("R8 pos untouched", tmp, 32767);

    // R6 index
    w(4'd8, 63); w(4'd2, 2); w(4'd3, 5);
    pin_pulse(idx, 4);
    rd(4'd6, tmp); chk("R6 disabled pos", tmp, 32767);
    rd(4'd8, tmp); chk("R6 disabled flags", tmp, 0);
    w(4'd0, 12);
    pin_pulse(idx, 4);
    rd(4'd6, tmp); chk("R6 pos down", tmp, 2);
    rd(4'd7, tmp); chk("R6 rev down", tmp, 6);
    rd(4'd8, tmp); chk("R6 flag", tmp, 2);
    qstep(1'b1);
    pin_pulse(idx, 4);
    rd(4'd6, tmp); chk("R6 pos up", tmp, 2);
    rd(4'd7, tmp); chk("R6 rev up", tmp, 7);

    // R7 home
    w(4'd8, 63); w(4'd4, 4); w(4'd0, 20);
    pin_pulse(home, 4);
    rd(4'd6, tmp); chk("R7 pos", tmp, 4);
    rd(4'd7, tmp); chk("R7 rev", tmp, 7);
    rd(4'd8, tmp); chk("R7 flag", tmp, 1);

    // R9 / R10 match
    w(4'd8, 63); w(4'd5, 4); w(4'd0, 36); wait_n(2);
    chk("R9 match high", match, 1);
    rd(4'd8, tmp); chk("R10 event", tmp, 4);
    w(4'd8, 63); wait_n(3);
    rd(4'd8, tmp); chk("R10 one-shot", tmp, 0);
    chk("R9 still high", match, 1);
    qstep(1'b1);
    chk("R9 low off match", match, 0);
    qstep(1'b0);
    chk("R9 high again", match, 1);
    rd(4'd8, tmp); chk("R10 disarmed", tmp, 0);
    w(4'd0, 36); wait_n(2);
    rd(4'd8, tmp); chk("R10 re-armed", tmp, 4);

    // R12 pulse mode
    w(4'd0, 1); a = 1'b0; b = 1'b0; phase = 0; dir = 1'b0; wait_n(8);
    w(4'd2, 0); w(4'd3, 0); w(4'd6, 0);
    for (int k = 0; k < 3; k++) pin_pulse(a, 4);
    rd(4'd6, tmp); chk("R12 up", tmp, 3);
    dir = 1'b1; wait_n(8);
    for (int k = 0; k < 2; k++) pin_pulse(a, 4);
    rd(4'd6, tmp); chk("R12 down", tmp, 1);

    // R13 filter
    dir = 1'b0; w(4'd1, 4); wait_n(8);
    pin_pulse(a, 3);
    rd(4'd6, tmp); chk("R13 glitch dropped", tmp, 1);
    pin_pulse(a, 8);
    rd(4'd6, tmp); chk("R13 long accepted", tmp, 2);
    w(4'd1, 0);
    pin_pulse(a, 1);
    rd(4'd6, tmp); chk("R13 no filter", tmp, 3);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule